// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block keeps the results of instructions that an out-of-order core has started but not yet retired. Instructions claim a slot at issue, strictly in program order, and get a tag back. Functional units return results, together with an optional fault flag and cause code, in any order and addressed by that tag. The block retires the oldest slot once it is complete, so architectural register writes leave in program order, one per cycle at most.

A fault is held in its slot and acts only once that slot is the oldest. At that point the block raises a one-cycle trap report carrying the cause, the PC and the tag of the faulting instruction, and it discards every slot. When a branch turns out to be mispredicted, a squash input naming the branch's tag discards every slot younger than the branch and rewinds allocation to the slot right after it. Squashed results and squashed faults never leave the block. Issue logic can also ask, for each source register, whether an in-flight instruction will write it. If so, the block returns that instruction's tag and, once the result is in, the value itself.

Top module: `rob_commit_buffer`

## Requirements
- R1: After reset the buffer is empty: `issue_ready_o` is 1, `issue_tag_o` is 0, and no commit, trap or lookup hit is reported.
- R2: Accepted issues receive consecutive tags modulo DEPTH (8 by default). While DEPTH slots are occupied, `issue_ready_o` is 0 and the request is ignored.
- R3: Results may return in any order. `commit_valid_o` is raised only for the oldest slot, and only once its result has returned without a fault. At most one slot retires per cycle, and retired tags follow program order.
- R4: A fault returned for a slot is reported only when that slot is the oldest. In that cycle `exc_valid_o` is 1 for one cycle with the slot's cause (4 bits), PC and tag, and `commit_valid_o` is 0. From the next cycle the buffer is empty and the next tag equals the faulting tag.
- R5: When several slots hold faults, only the oldest is reported. All younger faults are discarded with the buffer.
- R6: A squash with tag T keeps T and everything older, and discards every younger slot in the same cycle. The next issue gets tag T+1 (mod DEPTH). Discarded slots never commit and their faults never trap.
- R7: A result addressed to a tag that holds no live slot, including a slot discarded in the same cycle, changes nothing.
- R8: For each lookup port, `lk_hit_o` is 1 when a live slot writes the looked-up register. `lk_tag_o` is the youngest such slot, and `lk_ready_o` is 1 with `lk_data_o` valid when that slot's result is in and carries no fault.
- R9: While a trap is being reported or a squash input is active, `issue_ready_o` is 0 and no slot is allocated.
- R10: `commit_we_o` is 1 only for instructions issued with `issue_we_i` = 1. Slots issued with `issue_we_i` = 0 never match a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_we_i | input | 1 | Instruction writes a destination register |
| issue_dest_i | input | REG_W | Destination register index |
| issue_pc_i | input | PC_W | Instruction PC |
| issue_ready_o | output | 1 | A slot can be allocated this cycle |
| issue_tag_o | output | TAG_W | Tag given to the next accepted issue |
| wb_valid_i | input | 1 | Result return |
| wb_tag_i | input | TAG_W | Tag of the returning result |
| wb_data_i | input | DATA_W | Result value |
| wb_exc_i | input | 1 | Result carries a fault |
| wb_cause_i | input | 4 | Fault cause code |
| flush_valid_i | input | 1 | Mispredict squash |
| flush_tag_i | input | TAG_W | Tag of the mispredicted branch |
| lk_reg_i | input | NUM_RD*REG_W | Looked-up register per port |
| lk_hit_o | output | NUM_RD | An in-flight slot writes the register |
| lk_ready_o | output | NUM_RD | That slot's value is available |
| lk_tag_o | output | NUM_RD*TAG_W | Tag of the youngest matching slot |
| lk_data_o | output | NUM_RD*DATA_W | Value of the youngest matching slot |
| commit_valid_o | output | 1 | Oldest slot retires this cycle |
| commit_we_o | output | 1 | Retiring slot writes a register |
| commit_dest_o | output | REG_W | Retiring destination register |
| commit_data_o | output | DATA_W | Retiring value |
| commit_tag_o | output | TAG_W | Retiring tag |
| exc_valid_o | output | 1 | Precise trap report |
| exc_cause_o | output | 4 | Trap cause code |
| exc_pc_o | output | PC_W | PC of the faulting instruction |
| exc_tag_o | output | TAG_W | Tag of the faulting instruction |

## Verification
The checks assume three things about the inputs. A result is returned at most once per live slot, and never for a slot that already completed. A squash names a slot that is live in that cycle. Issue is only counted when `issue_ready_o` is high in the same cycle. The stimulus meets these by drawing result and squash tags from the slots its own behavioural model holds. It returns results only for slots the model still shows as pending. On purpose, it also sends results to the free slot at the allocation point, to exercise the ignore rule. Directed runs cover these cases: a full buffer, results returned in reverse order, two faults where the younger one returns first, a squash that covers a faulting slot, and lookups that must skip slots which do not write a register. Mixed runs then vary how often issue, results, faults and squashes occur.

// File: rtl/rob_commit_pkg.sv
package rob_commit_pkg;

  localparam int unsigned CAUSE_W = 4;

  typedef enum logic [1:0] {
    RET_IDLE   = 2'd0,
    RET_COMMIT = 2'd1,
    RET_TRAP   = 2'd2
  } retire_e;

endpackage

// File: rtl/rob_commit_ptr.sv
module rob_commit_ptr #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             trap_i,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] flush_off_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [PTR_W-1:0] occ_o,
  output logic             full_o,
  output logic             empty_o
);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;

  always_comb begin
    head_d = head_q + PTR_W'(retire_i);
    if (trap_i) begin
      tail_d = head_q;
    end else if (flush_i) begin
      // keep the branch slot, cut everything after it
      tail_d = head_q + PTR_W'(flush_off_i) + PTR_W'(1);
    end else begin
      tail_d = tail_q + PTR_W'(alloc_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign occ_o   = tail_q - head_q;
  assign full_o  = (occ_o == PTR_W'(DEPTH));
  assign empty_o = (tail_q == head_q);

endmodule

// File: rtl/rob_commit_lookup.sv
module rob_commit_lookup #(
  parameter  int unsigned DEPTH  = 8,
  parameter  int unsigned REG_W  = 5,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned TAG_W  = $clog2(DEPTH)
) (
  input  logic [REG_W-1:0]             reg_i,
  input  logic [TAG_W-1:0]             head_i,
  input  logic [DEPTH-1:0]             live_i,
  input  logic [DEPTH-1:0]             we_i,
  input  logic [DEPTH-1:0]             done_i,
  input  logic [DEPTH-1:0]             exc_i,
  input  logic [DEPTH-1:0][REG_W-1:0]  dest_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_i,
  output logic                         hit_o,
  output logic                         ready_o,
  output logic [TAG_W-1:0]             tag_o,
  output logic [DATA_W-1:0]            data_o
);

  logic [TAG_W-1:0] idx;

  // walk oldest to youngest, last match wins
  always_comb begin
    hit_o   = 1'b0;
    ready_o = 1'b0;
    tag_o   = '0;
    data_o  = '0;
    idx     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + TAG_W'(k);
      if (live_i[idx] && we_i[idx] && (dest_i[idx] == reg_i)) begin
        hit_o   = 1'b1;
        ready_o = done_i[idx] && !exc_i[idx];
        tag_o   = idx;
        data_o  = data_i[idx];
      end
    end
  end

endmodule

// File: rtl/rob_commit_buffer.sv
module rob_commit_buffer
  import rob_commit_pkg::*;
#(
  parameter  int unsigned DEPTH  = 8,
  parameter  int unsigned REG_W  = 5,
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned PC_W   = 32,
  parameter  int unsigned NUM_RD = 2,
  localparam int unsigned TAG_W  = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     issue_valid_i,
  input  logic                     issue_we_i,
  input  logic [REG_W-1:0]         issue_dest_i,
  input  logic [PC_W-1:0]          issue_pc_i,
  output logic                     issue_ready_o,
  output logic [TAG_W-1:0]         issue_tag_o,
  input  logic                     wb_valid_i,
  input  logic [TAG_W-1:0]         wb_tag_i,
  input  logic [DATA_W-1:0]        wb_data_i,
  input  logic                     wb_exc_i,
  input  logic [CAUSE_W-1:0]       wb_cause_i,
  input  logic                     flush_valid_i,
  input  logic [TAG_W-1:0]         flush_tag_i,
  input  logic [NUM_RD*REG_W-1:0]  lk_reg_i,
  output logic [NUM_RD-1:0]        lk_hit_o,
  output logic [NUM_RD-1:0]        lk_ready_o,
  output logic [NUM_RD*TAG_W-1:0]  lk_tag_o,
  output logic [NUM_RD*DATA_W-1:0] lk_data_o,
  output logic                     commit_valid_o,
  output logic                     commit_we_o,
  output logic [REG_W-1:0]         commit_dest_o,
  output logic [DATA_W-1:0]        commit_data_o,
  output logic [TAG_W-1:0]         commit_tag_o,
  output logic                     exc_valid_o,
  output logic [CAUSE_W-1:0]       exc_cause_o,
  output logic [PC_W-1:0]          exc_pc_o,
  output logic [TAG_W-1:0]         exc_tag_o
);

  localparam int unsigned PTR_W = TAG_W + 1;

  logic [PTR_W-1:0] head_q, tail_q, occ;
  logic             full, empty;
  logic [TAG_W-1:0] head_idx, tail_idx, flush_off;

  logic [DEPTH-1:0]               vld_q, done_q, exc_q, we_q, squash;
  logic [DEPTH-1:0][REG_W-1:0]    dest_q;
  logic [DEPTH-1:0][PC_W-1:0]     pc_q;
  logic [DEPTH-1:0][DATA_W-1:0]   data_q;
  logic [DEPTH-1:0][CAUSE_W-1:0]  cause_q;

  retire_e ret_kind;
  logic    retire, trap, alloc;

  assign head_idx  = head_q[TAG_W-1:0];
  assign tail_idx  = tail_q[TAG_W-1:0];
  assign flush_off = flush_tag_i - head_idx;

  always_comb begin
    ret_kind = RET_IDLE;
    if (!empty && done_q[head_idx]) begin
      ret_kind = exc_q[head_idx] ? RET_TRAP : RET_COMMIT;
    end
  end

  assign retire        = (ret_kind == RET_COMMIT);
  assign trap          = (ret_kind == RET_TRAP);
  assign issue_ready_o = !full && !trap && !flush_valid_i;
  assign alloc         = issue_valid_i && issue_ready_o;
  assign issue_tag_o   = tail_idx;

  rob_commit_ptr #(
    .DEPTH(DEPTH)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (alloc),
    .retire_i   (retire),
    .trap_i     (trap),
    .flush_i    (flush_valid_i),
    .flush_off_i(flush_off),
    .head_o     (head_q),
    .tail_o     (tail_q),
    .occ_o      (occ),
    .full_o     (full),
    .empty_o    (empty)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [TAG_W-1:0] IDX = TAG_W'(g);

    logic [TAG_W-1:0]   ent_off;
    logic               vld_r, done_r, exc_r, we_r;
    logic [REG_W-1:0]   dest_r;
    logic [PC_W-1:0]    pc_r;
    logic [DATA_W-1:0]  data_r;
    logic [CAUSE_W-1:0] cause_r;

    assign ent_off   = IDX - head_idx;
    // younger than the branch in program order
    assign squash[g] = flush_valid_i && !trap && (ent_off > flush_off);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_r   <= 1'b0;
        done_r  <= 1'b0;
        exc_r   <= 1'b0;
        we_r    <= 1'b0;
        dest_r  <= '0;
        pc_r    <= '0;
        data_r  <= '0;
        cause_r <= '0;
      end else if (trap) begin
        vld_r <= 1'b0;
      end else if (alloc && (tail_idx == IDX)) begin
        vld_r  <= 1'b1;
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        we_r   <= issue_we_i;
        dest_r <= issue_dest_i;
        pc_r   <= issue_pc_i;
      end else if ((retire && (head_idx == IDX)) || squash[g]) begin
        vld_r <= 1'b0;
      end else if (wb_valid_i && vld_r && (wb_tag_i == IDX)) begin
        done_r  <= 1'b1;
        exc_r   <= wb_exc_i;
        data_r  <= wb_data_i;
        cause_r <= wb_cause_i;
      end
    end

    assign vld_q[g]   = vld_r;
    assign done_q[g]  = done_r;
    assign exc_q[g]   = exc_r;
    assign we_q[g]    = we_r;
    assign dest_q[g]  = dest_r;
    assign pc_q[g]    = pc_r;
    assign data_q[g]  = data_r;
    assign cause_q[g] = cause_r;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_lk
    rob_commit_lookup #(
      .DEPTH (DEPTH),
      .REG_W (REG_W),
      .DATA_W(DATA_W)
    ) u_lk (
      .reg_i  (lk_reg_i[p*REG_W +: REG_W]),
      .head_i (head_idx),
      .live_i (vld_q),
      .we_i   (we_q),
      .done_i (done_q),
      .exc_i  (exc_q),
      .dest_i (dest_q),
      .data_i (data_q),
      .hit_o  (lk_hit_o[p]),
      .ready_o(lk_ready_o[p]),
      .tag_o  (lk_tag_o[p*TAG_W +: TAG_W]),
      .data_o (lk_data_o[p*DATA_W +: DATA_W])
    );
  end

  assign commit_valid_o = retire;
  assign commit_we_o    = we_q[head_idx];
  assign commit_dest_o  = dest_q[head_idx];
  assign commit_data_o  = data_q[head_idx];
  assign commit_tag_o   = head_idx;

  assign exc_valid_o = trap;
  assign exc_cause_o = cause_q[head_idx];
  assign exc_pc_o    = pc_q[head_idx];
  assign exc_tag_o   = head_idx;

endmodule

// File: rtl/rob_commit_buffer_chk.sv
module rob_commit_buffer_chk #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             issue_ready_o,
  input logic [TAG_W-1:0] issue_tag_o,
  input logic             flush_valid_i,
  input logic [TAG_W-1:0] flush_tag_i,
  input logic             commit_valid_o,
  input logic [TAG_W-1:0] commit_tag_o,
  input logic             exc_valid_o,
  input logic [TAG_W:0]   occ_i
);

  p_occ_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= (TAG_W+1)'(DEPTH));

  p_full_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i == (TAG_W+1)'(DEPTH)) |-> !issue_ready_o);

  p_tag_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_o) |=> (issue_tag_o == $past(issue_tag_o) + 1'b1));

  p_commit_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_o && $past(commit_valid_o)) |-> (commit_tag_o == $past(commit_tag_o) + 1'b1));

  p_trap_drains_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |=> (occ_i == '0) && !exc_valid_o && !commit_valid_o);

  p_flush_rewind_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_valid_i && !exc_valid_o) |=> (issue_tag_o == $past(flush_tag_i) + 1'b1));

endmodule

bind rob_commit_buffer rob_commit_buffer_chk #(
  .DEPTH(DEPTH)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_ready_o (issue_ready_o),
  .issue_tag_o   (issue_tag_o),
  .flush_valid_i (flush_valid_i),
  .flush_tag_i   (flush_tag_i),
  .commit_valid_o(commit_valid_o),
  .commit_tag_o  (commit_tag_o),
  .exc_valid_o   (exc_valid_o),
  .occ_i         (occ)
);

// File: tb/rob_commit_buffer_tb_top.sv
module rob_commit_buffer_tb_top;
  import rob_commit_pkg::*;

  localparam int DEPTH  = 8;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int PC_W   = 32;
  localparam int NUM_RD = 2;
  localparam int TAG_W  = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;

  logic                     issue_valid_i = 1'b0, issue_we_i = 1'b0;
  logic [REG_W-1:0]         issue_dest_i = '0;
  logic [PC_W-1:0]          issue_pc_i = '0;
  logic                     issue_ready_o;
  logic [TAG_W-1:0]         issue_tag_o;
  logic                     wb_valid_i = 1'b0, wb_exc_i = 1'b0;
  logic [TAG_W-1:0]         wb_tag_i = '0;
  logic [DATA_W-1:0]        wb_data_i = '0;
  logic [CAUSE_W-1:0]       wb_cause_i = '0;
  logic                     flush_valid_i = 1'b0;
  logic [TAG_W-1:0]         flush_tag_i = '0;
  logic [NUM_RD*REG_W-1:0]  lk_reg_i = '0;
  logic [NUM_RD-1:0]        lk_hit_o, lk_ready_o;
  logic [NUM_RD*TAG_W-1:0]  lk_tag_o;
  logic [NUM_RD*DATA_W-1:0] lk_data_o;
  logic                     commit_valid_o, commit_we_o;
  logic [REG_W-1:0]         commit_dest_o;
  logic [DATA_W-1:0]        commit_data_o;
  logic [TAG_W-1:0]         commit_tag_o;
  logic                     exc_valid_o;
  logic [CAUSE_W-1:0]       exc_cause_o;
  logic [PC_W-1:0]          exc_pc_o;
  logic [TAG_W-1:0]         exc_tag_o;

  typedef struct {
    int                tag;
    bit                we;
    int                dest;
    logic [PC_W-1:0]   pc;
    bit                done;
    bit                exc;
    int                cause;
    logic [DATA_W-1:0] data;
  } ent_t;

  ent_t q[$];
  int next_tag = 0;
  int pc_ctr = 0;
  int checks = 0;
  int fails = 0;
  int lk_sel0 = 3;
  int lk_sel1 = 4;

  rob_commit_buffer #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W), .NUM_RD(NUM_RD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid_i), .issue_we_i(issue_we_i), .issue_dest_i(issue_dest_i),
    .issue_pc_i(issue_pc_i), .issue_ready_o(issue_ready_o), .issue_tag_o(issue_tag_o),
    .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
    .wb_exc_i(wb_exc_i), .wb_cause_i(wb_cause_i),
    .flush_valid_i(flush_valid_i), .flush_tag_i(flush_tag_i),
    .lk_reg_i(lk_reg_i), .lk_hit_o(lk_hit_o), .lk_ready_o(lk_ready_o),
    .lk_tag_o(lk_tag_o), .lk_data_o(lk_data_o),
    .commit_valid_o(commit_valid_o), .commit_we_o(commit_we_o), .commit_dest_o(commit_dest_o),
    .commit_data_o(commit_data_o), .commit_tag_o(commit_tag_o),
    .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o), .exc_pc_o(exc_pc_o),
    .exc_tag_o(exc_tag_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find_tag(input int t);
    for (int i = 0; i < q.size(); i++) if (q[i].tag == t) return i;
    return -1;
  endfunction

  task automatic compare();
    int n;
    bit trap_e, com_e;
    n      = q.size();
    trap_e = (n > 0) && q[0].done && q[0].exc;
    com_e  = (n > 0) && q[0].done && !q[0].exc;
    chk("R2/R9", "issue_ready", 64'(issue_ready_o), 64'((n < DEPTH) && !trap_e && !flush_valid_i));
    chk("R2/R6", "issue_tag", 64'(issue_tag_o), 64'(next_tag));
    chk("R3", "commit_valid", 64'(commit_valid_o), 64'(com_e));
    if (com_e) begin
      chk("R3", "commit_tag", 64'(commit_tag_o), 64'(q[0].tag));
      chk("R3/R7", "commit_data", 64'(commit_data_o), 64'(q[0].data));
      chk("R10", "commit_we", 64'(commit_we_o), 64'(q[0].we));
      if (q[0].we) chk("R3", "commit_dest", 64'(commit_dest_o), 64'(q[0].dest));
    end
    chk("R4/R5", "exc_valid", 64'(exc_valid_o), 64'(trap_e));
    if (trap_e) begin
      chk("R4", "exc_cause", 64'(exc_cause_o), 64'(q[0].cause));
      chk("R4", "exc_pc", 64'(exc_pc_o), 64'(q[0].pc));
      chk("R5", "exc_tag", 64'(exc_tag_o), 64'(q[0].tag));
    end
    for (int p = 0; p < NUM_RD; p++) begin
      int rg, idx;
      rg  = int'(lk_reg_i[p*REG_W +: REG_W]);
      idx = -1;
      for (int i = 0; i < n; i++) if (q[i].we && q[i].dest == rg) idx = i;
      chk("R8/R10", "lk_hit", 64'(lk_hit_o[p]), 64'(idx >= 0));
      if (idx >= 0) begin
        chk("R8", "lk_tag", 64'(lk_tag_o[p*TAG_W +: TAG_W]), 64'(q[idx].tag));
        chk("R8", "lk_ready", 64'(lk_ready_o[p]), 64'(q[idx].done && !q[idx].exc));
        if (q[idx].done && !q[idx].exc)
          chk("R8", "lk_data", 64'(lk_data_o[p*DATA_W +: DATA_W]), 64'(q[idx].data));
      end
    end
  endtask

  task automatic step(input bit iv, input bit iwe, input int idest, input bit wv,
                      input int wtag, input bit wexc, input int wcause,
                      input logic [DATA_W-1:0] wdata, input bit fv, input int ftag);
    int n, j;
    bit trap_e, com_e, rdy_e;
    ent_t e;
    @(negedge clk);
    issue_valid_i = iv;
    issue_we_i    = iwe;
    issue_dest_i  = REG_W'(idest);
    issue_pc_i    = PC_W'(pc_ctr * 4);
    wb_valid_i    = wv;
    wb_tag_i      = TAG_W'(wtag);
    wb_exc_i      = wexc;
    wb_cause_i    = CAUSE_W'(wcause);
    wb_data_i     = wdata;
    flush_valid_i = fv;
    flush_tag_i   = TAG_W'(ftag);
    lk_reg_i      = {REG_W'(lk_sel1), REG_W'(lk_sel0)};
    #1;
    compare();
    n      = q.size();
    trap_e = (n > 0) && q[0].done && q[0].exc;
    com_e  = (n > 0) && q[0].done && !q[0].exc;
    rdy_e  = (n < DEPTH) && !trap_e && !fv;
    @(posedge clk);
    if (trap_e) begin
      next_tag = q[0].tag;
      q.delete();
    end else begin
      if (fv) begin
        j = find_tag(ftag);
        if (j >= 0) while (q.size() > j + 1) void'(q.pop_back());
        next_tag = (ftag + 1) % DEPTH;
      end
      if (wv) begin
        j = find_tag(wtag);
        if (j >= 0) begin
          q[j].done  = 1'b1;
          q[j].exc   = wexc;
          q[j].cause = wcause;
          q[j].data  = wdata;
        end
      end
      if (com_e) void'(q.pop_front());
      if (iv && rdy_e) begin
        e.tag = next_tag; e.we = iwe; e.dest = idest; e.pc = PC_W'(pc_ctr * 4);
        e.done = 1'b0; e.exc = 1'b0; e.cause = 0; e.data = '0;
        q.push_back(e);
        next_tag = (next_tag + 1) % DEPTH;
        pc_ctr++;
      end
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 0);
  endtask

  task automatic iss(input bit we, input int dest);
    step(1, we, dest, 0, 0, 0, 0, '0, 0, 0);
  endtask

  task automatic wb(input int k, input bit ex, input int cause);
    step(0, 0, 0, 1, q[k].tag, ex, cause, DATA_W'($urandom), 0, 0);
  endtask

  task automatic rnd(input int pi, input int pw, input int pe, input int pf, input int pd);
    bit iv, iwe, wv, wexc, fv;
    int idest, wtag, ftag, k;
    int cand[$];
    iv    = ($urandom_range(0, 99) < pi);
    iwe   = ($urandom_range(0, 3) != 0);
    idest = $urandom_range(0, 7);
    wv = 0; wtag = 0; wexc = 0; fv = 0; ftag = 0;
    for (int i = 0; i < q.size(); i++) if (!q[i].done) cand.push_back(i);
    if (cand.size() > 0 && $urandom_range(0, 99) < pw) begin
      k    = cand[$urandom_range(0, cand.size() - 1)];
      wv   = 1;
      wtag = q[k].tag;
      wexc = ($urandom_range(0, 99) < pe);
    end else if (q.size() < DEPTH && $urandom_range(0, 99) < pd) begin
      wv   = 1;          // R7: free slot, must be ignored
      wtag = next_tag;
      wexc = $urandom_range(0, 1);
    end
    if (q.size() > 0 && $urandom_range(0, 99) < pf) begin
      fv   = 1;
      ftag = q[$urandom_range(0, q.size() - 1)].tag;
    end
    lk_sel0 = $urandom_range(0, 7);
    lk_sel1 = $urandom_range(0, 7);
    step(iv, iwe, idest, wv, wtag, wexc, $urandom_range(0, 15), DATA_W'($urandom), fv, ftag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t3, tf;
    void'($urandom(7));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "reset ready", 64'(issue_ready_o), 64'd1);
    chk("R1", "reset tag", 64'(issue_tag_o), 64'd0);
    chk("R1", "reset commit", 64'(commit_valid_o), 64'd0);
    chk("R1", "reset exc", 64'(exc_valid_o), 64'd0);
    chk("R1", "reset lk_hit", 64'(lk_hit_o), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: fill to capacity, one extra request is refused
    for (int i = 0; i < DEPTH; i++) iss(1, (i % 7) + 1);
    iss(1, 2);
    // R3: results return youngest first, retirement waits for the oldest
    for (int k = DEPTH - 1; k >= 0; k--) wb(k, 0, 0);
    repeat (DEPTH + 2) idle();

    // R5: two faults, younger returns first
    for (int i = 0; i < 4; i++) iss(1, 6);
    wb(2, 1, 5);
    wb(1, 1, 3);
    wb(3, 0, 0);
    wb(0, 0, 0);
    repeat (4) idle();
    chk("R4", "drained ready", 64'(issue_ready_o), 64'd1);

    // R6: squash covers a faulting slot; R7: result to discarded slot
    for (int i = 0; i < 5; i++) iss(1, 5);
    t3 = q[3].tag;
    tf = q[1].tag;
    wb(3, 1, 9);
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, tf);
    step(0, 0, 0, 1, t3, 1, 12, 32'hdead_beef, 0, 0);
    wb(0, 0, 0);
    wb(1, 0, 0);
    repeat (4) idle();
    iss(1, 1);
    iss(1, 1);
    iss(1, 1);
    repeat (3) idle();
    for (int k = 0; k < 3; k++) wb(0, 0, 0);
    repeat (3) idle();

    // R8/R10: lookups skip non-writing slots, pick the youngest writer
    lk_sel0 = 3;
    lk_sel1 = 4;
    iss(1, 3);
    iss(0, 3);
    iss(1, 4);
    iss(1, 4);
    idle();
    wb(3, 0, 0);
    wb(0, 0, 0);
    idle();
    wb(0, 0, 0);
    wb(0, 0, 0);
    wb(0, 0, 0);
    repeat (4) idle();

    repeat (2000) rnd(70, 50, 10, 5, 5);
    repeat (1000) rnd(90, 20, 5, 3, 10);
    repeat (1000) rnd(60, 60, 40, 10, 5);
    repeat (DEPTH * 3) rnd(0, 100, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule